// File: doc/BRIEF.md
# Color LCD Controller Register Interface

This block is the slave register file of a color LCD controller. A processor reaches it over a simple 32-bit word bus made of a select strobe, a write flag, a 10-bit word address and the write data. Read data is combinational: it is valid in the same cycle as the select. The block stores four timing words, the base addresses of the upper and lower panel frames, a control word, an interrupt mask and a sticky raw interrupt status. It also decodes the panel geometry, the pixel depth, the pixel ordering and the display-active state from those words. It drives these decoded values to the display datapath.

Raw status bits are set by single-cycle event pulses from the datapath. Software clears them by writing ones to a clear location. A fixed window returns eight identification bytes. A second window of 128 words is not stored here. Accesses to it go out to a separate palette block, and that block's read data comes back through this one. Any other word address is unmapped. An unmapped read returns zero, an unmapped write changes nothing, and either one raises a one-cycle error pulse on the next cycle.

Top module: `lcd_reg_if`

## Requirements
- R1: After reset, every stored register reads zero, the width output is 16, the height output is 1, the mode, order and active outputs are 0, and the error output is low.
- R2: Word addresses 0–7 (timing 0–3, upper base, lower base, mask, control) are writable and read back what was written. The mask keeps only its low IRQ_W bits, and its upper bits read as zero. The decoded outputs follow a write on the next cycle.
- R3: The width output equals (timing0[7:2] + 1) × 16. Other bits of timing0 have no effect on it.
- R4: The height output equals timing1[9:0] + 1. Bits above 9 have no effect on it.
- R5: The active output is 1 only when control bit 0 (enable) and control bit 11 (power) are both 1.
- R6: The mode output equals control[3:1]. The codes are 0=1, 1=2, 2=4, 3=8, 4=16 and 5=32 bits per pixel, and codes 6 and 7 pass through unchanged.
- R7: The order output is 1 (big-endian bytes) when control bit 9 is set. Otherwise it is 2 (big-endian pixels in a byte) when control bit 10 is set, and 0 when neither is set. Bit 9 wins when both are set.
- R8: A high bit of the event input sets the matching raw status bit, and the bit stays set. Word 8 reads the raw status. Word 9 reads raw AND mask. A write to word 10 clears each raw bit whose data bit is 1. When an event and a clear hit the same bit in the same cycle, the set wins. Word 10 reads as zero.
- R9: Words 11 and 12 read the upper and lower base registers. Writes to words 8, 9, 11, 12 and to the identification window change nothing.
- R10: Words 0x3F8–0x3FF read, in address order, 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, zero-extended.
- R11: Words 0x080–0x0FF assert the palette select with index = address[6:0], the palette write flag = the bus write flag, and the palette write data = the bus data. A read there returns the palette read data. No other access asserts the palette select.
- R12: Every other word address (13–0x07F, 0x100–0x3F7) reads as zero and ignores writes. The error output is 1 for exactly the cycle after each such access, and 0 after any mapped access or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Unmapped-access pulse, one cycle late |
| evt_in | input | IRQ_W | Raw status set pulses |
| pal_sel | output | 1 | Palette access strobe |
| pal_wr | output | 1 | Palette write flag |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |
| pix_w | output | 11 | Panel width in pixels |
| pix_h | output | 11 | Panel height in lines |
| pix_mode | output | 3 | Pixel depth code |
| pix_order | output | 2 | Byte/pixel order code |
| disp_on | output | 1 | Display active |

## Verification
The width and height decode is driven with the all-ones field, the zero field, and mid-range values in which the bits outside the field are set. This separates a wrong field slice from a wrong scale or a missing +1. The control word is stepped through every mode code and through each enable/power pair and order-bit pair, so a swapped bit or a lost priority shows up. The status logic is driven with events alone, clears alone, and an event and a clear in the same cycle on the same bit, with a partial mask in place. Unmapped addresses are probed at both edges of each gap, which catches off-by-one region bounds.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
    localparam int WA = 10;
    localparam int DW = 32;

    localparam int CB_EN      = 0;
    localparam int CB_MODE_LO = 1;
    localparam int CB_BE_BYTE = 9;
    localparam int CB_BE_PIX  = 10;
    localparam int CB_PWR     = 11;

    localparam int PPL_LO     = 2;
    localparam int PPL_HI     = 7;
    localparam int PPL_W      = PPL_HI - PPL_LO + 1;
    localparam int LPP_W      = 10;
    localparam int PPL_SHIFT  = 4;
    localparam int GEOM_W     = 11;

    localparam int                REG_WORDS = 13;
    localparam int                PAL_IDX_W = 7;
    localparam logic [WA-1:0]     PAL_FIRST = 10'h080;
    localparam logic [WA-1:0]     PAL_LAST  = 10'h0FF;
    localparam logic [WA-1:0]     ID_FIRST  = 10'h3F8;

    typedef enum logic [2:0] {
        MODE_1B  = 3'd0,
        MODE_2B  = 3'd1,
        MODE_4B  = 3'd2,
        MODE_8B  = 3'd3,
        MODE_16B = 3'd4,
        MODE_32B = 3'd5,
        MODE_R6  = 3'd6,
        MODE_R7  = 3'd7
    } pix_mode_e;

    typedef enum logic [1:0] {
        ORD_LE      = 2'd0,
        ORD_BE_BYTE = 2'd1,
        ORD_BE_PIX  = 2'd2
    } pix_order_e;

    typedef enum logic [3:0] {
        RG_NONE, RG_TIM, RG_UBASE, RG_LBASE, RG_MASK, RG_CTRL,
        RG_RAW, RG_MSTAT, RG_CLR, RG_UCUR, RG_LCUR, RG_PAL, RG_ID
    } region_e;

    typedef struct packed {
        region_e               kind;
        logic [1:0]            tim_sel;
        logic [PAL_IDX_W-1:0]  pal_idx;
        logic [2:0]            id_idx;
    } decode_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h10;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/lcdr_decode.sv
module lcdr_decode
    import lcdr_pkg::*;
(
    input  logic [WA-1:0] waddr,
    output decode_t       dec
);
    always_comb begin
        dec = '{kind: RG_NONE, tim_sel: 2'd0, pal_idx: '0, id_idx: 3'd0};
        if (waddr < WA'(REG_WORDS)) begin
            case (waddr[3:0])
                4'd0, 4'd1, 4'd2, 4'd3: begin
                    dec.kind    = RG_TIM;
                    dec.tim_sel = waddr[1:0];
                end
                4'd4:    dec.kind = RG_UBASE;
                4'd5:    dec.kind = RG_LBASE;
                4'd6:    dec.kind = RG_MASK;
                4'd7:    dec.kind = RG_CTRL;
                4'd8:    dec.kind = RG_RAW;
                4'd9:    dec.kind = RG_MSTAT;
                4'd10:   dec.kind = RG_CLR;
                4'd11:   dec.kind = RG_UCUR;
                4'd12:   dec.kind = RG_LCUR;
                default: dec.kind = RG_NONE;
            endcase
        end else if (waddr >= PAL_FIRST && waddr <= PAL_LAST) begin
            dec.kind    = RG_PAL;
            dec.pal_idx = waddr[PAL_IDX_W-1:0];
        end else if (waddr >= ID_FIRST) begin
            dec.kind   = RG_ID;
            dec.id_idx = waddr[2:0];
        end
    end
endmodule

// File: rtl/lcdr_regs.sv
module lcdr_regs
    import lcdr_pkg::*;
#(
    parameter int IRQ_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  decode_t          dec,
    input  logic [DW-1:0]    wdata,
    input  logic [IRQ_W-1:0] evt,
    output logic [DW-1:0]    tim_q [4],
    output logic [DW-1:0]    ubase_q,
    output logic [DW-1:0]    lbase_q,
    output logic [DW-1:0]    ctrl_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic [IRQ_W-1:0] raw_q
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = (wr_en && dec.kind == RG_CLR) ? wdata[IRQ_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) tim_q[i] <= '0;
            ubase_q <= '0;
            lbase_q <= '0;
            ctrl_q  <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (dec.kind)
                RG_TIM:   tim_q[dec.tim_sel] <= wdata;
                RG_UBASE: ubase_q <= wdata;
                RG_LBASE: lbase_q <= wdata;
                RG_CTRL:  ctrl_q  <= wdata;
                RG_MASK:  mask_q  <= wdata[IRQ_W-1:0];
                default:  ;
            endcase
        end
    end

    // events win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~clr_bits) | evt;
    end
endmodule

// File: rtl/lcdr_geom.sv
module lcdr_geom
    import lcdr_pkg::*;
(
    input  logic [PPL_W-1:0]  ppl_fld,
    input  logic [LPP_W-1:0]  lpp_fld,
    input  logic              en_bit,
    input  logic              pwr_bit,
    input  logic [2:0]        mode_fld,
    input  logic              be_byte_bit,
    input  logic              be_pix_bit,
    output logic [GEOM_W-1:0] width_px,
    output logic [GEOM_W-1:0] height_ln,
    output pix_mode_e         mode,
    output pix_order_e        order,
    output logic              active
);
    localparam int UNITS_W = GEOM_W - PPL_SHIFT;

    logic [UNITS_W-1:0] units;

    assign units     = UNITS_W'(ppl_fld) + UNITS_W'(1);
    assign width_px  = {units, {PPL_SHIFT{1'b0}}};
    assign height_ln = GEOM_W'(lpp_fld) + GEOM_W'(1);
    assign active    = en_bit & pwr_bit;
    assign mode      = pix_mode_e'(mode_fld);

    always_comb begin
        if (be_byte_bit)     order = ORD_BE_BYTE;
        else if (be_pix_bit) order = ORD_BE_PIX;
        else                 order = ORD_LE;
    end
endmodule

// File: rtl/lcd_reg_if.sv
module lcd_reg_if
    import lcdr_pkg::*;
#(
    parameter int IRQ_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WA-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    input  logic [IRQ_W-1:0]  evt_in,
    output logic              pal_sel,
    output logic              pal_wr,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [DW-1:0]     pal_wdata,
    input  logic [DW-1:0]     pal_rdata,
    output logic [GEOM_W-1:0] pix_w,
    output logic [GEOM_W-1:0] pix_h,
    output logic [2:0]        pix_mode,
    output logic [1:0]        pix_order,
    output logic              disp_on
);
    decode_t          dec;
    logic             wr_en;
    logic [DW-1:0]    tim_q [4];
    logic [DW-1:0]    ubase_q, lbase_q, ctrl_q;
    logic [IRQ_W-1:0] mask_q, raw_q;
    pix_mode_e        mode_w;
    pix_order_e       order_w;

    assign wr_en = bus_sel & bus_wr;

    lcdr_decode u_dec (
        .waddr (bus_addr),
        .dec   (dec)
    );

    lcdr_regs #(.IRQ_W(IRQ_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .dec     (dec),
        .wdata   (bus_wdata),
        .evt     (evt_in),
        .tim_q   (tim_q),
        .ubase_q (ubase_q),
        .lbase_q (lbase_q),
        .ctrl_q  (ctrl_q),
        .mask_q  (mask_q),
        .raw_q   (raw_q)
    );

    lcdr_geom u_geom (
        .ppl_fld     (tim_q[0][PPL_HI:PPL_LO]),
        .lpp_fld     (tim_q[1][LPP_W-1:0]),
        .en_bit      (ctrl_q[CB_EN]),
        .pwr_bit     (ctrl_q[CB_PWR]),
        .mode_fld    (ctrl_q[CB_MODE_LO+2:CB_MODE_LO]),
        .be_byte_bit (ctrl_q[CB_BE_BYTE]),
        .be_pix_bit  (ctrl_q[CB_BE_PIX]),
        .width_px    (pix_w),
        .height_ln   (pix_h),
        .mode        (mode_w),
        .order       (order_w),
        .active      (disp_on)
    );

    assign pix_mode  = mode_w;
    assign pix_order = order_w;

    assign pal_sel   = bus_sel && dec.kind == RG_PAL;
    assign pal_wr    = pal_sel & bus_wr;
    assign pal_idx   = dec.pal_idx;
    assign pal_wdata = bus_wdata;

    always_comb begin
        case (dec.kind)
            RG_TIM:   bus_rdata = tim_q[dec.tim_sel];
            RG_UBASE,
            RG_UCUR:  bus_rdata = ubase_q;
            RG_LBASE,
            RG_LCUR:  bus_rdata = lbase_q;
            RG_CTRL:  bus_rdata = ctrl_q;
            RG_MASK:  bus_rdata = DW'(mask_q);
            RG_RAW:   bus_rdata = DW'(raw_q);
            RG_MSTAT: bus_rdata = DW'(raw_q & mask_q);
            RG_PAL:   bus_rdata = pal_rdata;
            RG_ID:    bus_rdata = DW'(id_byte(dec.id_idx));
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_err <= 1'b0;
        else     bus_err <= bus_sel && dec.kind == RG_NONE;
    end

    // R8: a written-one clear leaves the bit zero unless an event set it
    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.kind == RG_CLR)
        |=> ((raw_q & $past(bus_wdata[IRQ_W-1:0] & ~evt_in)) == '0));

    // R8: without a clear, set bits stay set
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dec.kind == RG_CLR)
        |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R12: an unmapped access is flagged on the next cycle
    a_r12_err_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_addr[9] && bus_addr[8:7] == 2'b00 && bus_addr >= WA'(REG_WORDS))
        |=> bus_err);

    // R12: an unmapped write leaves control and mask unchanged
    a_r12_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.kind == RG_NONE) |=> ($stable(ctrl_q) && $stable(mask_q)));

    // R2: control holds without a write to it
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dec.kind == RG_CTRL) |=> $stable(ctrl_q));

    // R11: palette strobe only inside its window
    a_r11_pal_window: assert property (@(posedge clk) disable iff (rst)
        pal_sel |-> (bus_sel && bus_addr[9:7] == 3'b001));

    // R3: width is a nonzero multiple of 16
    a_r3_width_scale: assert property (@(posedge clk) disable iff (rst)
        (pix_w[3:0] == 4'd0) && (pix_w != '0));
endmodule

// File: tb/sim_lcd_reg_if.sv
`timescale 1ns/1ps
module sim_lcd_reg_if;
    localparam int IW = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [IW-1:0] evt_in = '0;
    logic        pal_sel, pal_wr;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata, pal_rdata;
    logic [10:0] pix_w, pix_h;
    logic [2:0]  pix_mode;
    logic [1:0]  pix_order;
    logic        disp_on;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign pal_rdata = {8'hC3, 17'd0, pal_idx};

    lcd_reg_if #(.IRQ_W(IW)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .evt_in(evt_in), .pal_sel(pal_sel), .pal_wr(pal_wr),
        .pal_idx(pal_idx), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
        .pix_w(pix_w), .pix_h(pix_h), .pix_mode(pix_mode),
        .pix_order(pix_order), .disp_on(disp_on)
    );

    // ---- behavioural reference state ----
    logic [31:0]   m_tim [4];
    logic [31:0]   m_ub, m_lb, m_ctrl;
    logic [IW-1:0] m_mask, m_raw;
    logic          m_err;

    function automatic bit is_pal(input logic [9:0] a);
        return a >= 10'h080 && a <= 10'h0FF;
    endfunction
    function automatic bit is_id(input logic [9:0] a);
        return a >= 10'h3F8;
    endfunction
    function automatic bit unmapped(input logic [9:0] a);
        return a >= 10'd13 && !is_pal(a) && !is_id(a);
    endfunction
    function automatic logic [31:0] id_val(input int k);
        logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return {24'd0, t[k]};
    endfunction

    function automatic logic [31:0] mread(input logic [9:0] a);
        if (is_pal(a)) return {8'hC3, 17'd0, a[6:0]};
        if (is_id(a))  return id_val(int'(a - 10'h3F8));
        case (int'(a))
            0, 1, 2, 3: return m_tim[a[1:0]];
            4, 11:      return m_ub;
            5, 12:      return m_lb;
            6:          return {27'd0, m_mask};
            7:          return m_ctrl;
            8:          return {27'd0, m_raw};
            9:          return {27'd0, m_raw & m_mask};
            default:    return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_tim[i] = '0;
            m_ub = '0; m_lb = '0; m_ctrl = '0; m_mask = '0; m_raw = '0; m_err = 0;
        end else begin
            logic [IW-1:0] clr;
            clr = '0;
            m_err = bus_sel && unmapped(bus_addr);
            if (bus_sel && bus_wr) begin
                case (int'(bus_addr))
                    0, 1, 2, 3: m_tim[bus_addr[1:0]] = bus_wdata;
                    4:  m_ub = bus_wdata;
                    5:  m_lb = bus_wdata;
                    6:  m_mask = bus_wdata[IW-1:0];
                    7:  m_ctrl = bus_wdata;
                    10: clr = bus_wdata[IW-1:0];
                    default: ;
                endcase
            end
            m_raw = (m_raw & ~clr) | evt_in;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // decoded outputs and error flag compared every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [1:0] eord;
            eord = m_ctrl[9] ? 2'd1 : (m_ctrl[10] ? 2'd2 : 2'd0);
            chk("R3 width",  {21'd0, pix_w}, ((({26'd0, m_tim[0][7:2]}) + 32'd1) * 32'd16));
            chk("R4 height", {21'd0, pix_h}, {22'd0, m_tim[1][9:0]} + 32'd1);
            chk("R5 active", {31'd0, disp_on}, {31'd0, m_ctrl[0] & m_ctrl[11]});
            chk("R6 mode",   {29'd0, pix_mode}, {29'd0, m_ctrl[3:1]});
            chk("R7 order",  {30'd0, pix_order}, {30'd0, eord});
            chk("R12 err",   {31'd0, bus_err}, {31'd0, m_err});
        end
    end

    task automatic acc(input logic sel, input logic wr, input logic [9:0] a,
                       input logic [31:0] d, input logic [IW-1:0] ev, input string tag);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = ev;
        #1;
        if (sel && !wr) chk(tag, bus_rdata, mread(a));
        if (sel && is_pal(a)) begin
            chk("R11 pal_sel", {31'd0, pal_sel}, 32'd1);
            chk("R11 pal_idx", {25'd0, pal_idx}, {25'd0, a[6:0]});
            chk("R11 pal_wr",  {31'd0, pal_wr}, {31'd0, wr});
            if (wr) chk("R11 pal_wdata", pal_wdata, d);
        end else begin
            chk("R11 pal_sel idle", {31'd0, pal_sel}, 32'd0);
        end
        @(posedge clk);
    endtask

    task automatic wr_(input logic [9:0] a, input logic [31:0] d);
        acc(1, 1, a, d, '0, "wr");
    endtask
    task automatic rd(input logic [9:0] a, input string tag);
        acc(1, 0, a, 32'd0, '0, tag);
    endtask
    task automatic idle(input logic [IW-1:0] ev);
        acc(0, 0, 10'd0, 32'd0, ev, "idle");
    endtask
    task automatic dump(input string tag);
        for (int w = 0; w < 13; w++) rd(10'(w), tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        dump("R1 reset regs");

        // R2 register read/write
        for (int w = 0; w < 8; w++) wr_(10'(w), 32'h1357_9BDF ^ (32'h0101_0101 * w));
        dump("R2 readback");
        wr_(10'd6, 32'hFFFF_FFFF);
        rd(10'd6, "R2 mask width");

        // R3 width decode
        wr_(10'd0, 32'h0000_00FC); rd(10'd0, "R3 t0");
        wr_(10'd0, 32'hFFFF_FF03); idle('0);
        wr_(10'd0, 32'h0000_0028); idle('0);

        // R4 height decode
        wr_(10'd1, 32'h0000_03FF); idle('0);
        wr_(10'd1, 32'hFFFF_FC00); idle('0);
        wr_(10'd1, 32'h0000_01DF); idle('0);

        // R5 enable and power
        wr_(10'd7, 32'h0000_0001); idle('0);
        wr_(10'd7, 32'h0000_0800); idle('0);
        wr_(10'd7, 32'h0000_0801); idle('0);
        wr_(10'd7, 32'h0000_0000); idle('0);

        // R6 all mode codes
        for (int m = 0; m < 8; m++) begin
            wr_(10'd7, 32'h0000_0801 | (32'(m) << 1));
            rd(10'd7, "R6 ctrl");
        end

        // R7 order priority
        wr_(10'd7, 32'h0000_0200); idle('0);
        wr_(10'd7, 32'h0000_0400); idle('0);
        wr_(10'd7, 32'h0000_0600); idle('0);

        // R8 status set, mask, clear, collision
        wr_(10'd6, 32'h0000_0005);
        idle(5'b00011);
        rd(10'd8, "R8 raw");
        rd(10'd9, "R8 masked");
        idle(5'b10000);
        rd(10'd8, "R8 sticky");
        wr_(10'd10, 32'h0000_0001);
        rd(10'd8, "R8 after clear");
        rd(10'd10, "R8 clear reads zero");
        acc(1, 1, 10'd10, 32'h0000_0012, 5'b00010, "wr");
        rd(10'd8, "R8 set wins");
        rd(10'd9, "R8 masked2");
        wr_(10'd10, 32'hFFFF_FFFF);
        rd(10'd8, "R8 all cleared");

        // R9 current-address mirrors and read-only writes
        wr_(10'd4, 32'h8000_1000);
        wr_(10'd5, 32'h0040_2000);
        rd(10'd11, "R9 upper current");
        rd(10'd12, "R9 lower current");
        idle(5'b00100);
        wr_(10'd8, 32'h0); wr_(10'd9, 32'hFFFF_FFFF);
        wr_(10'd11, 32'h0); wr_(10'd12, 32'h0);
        wr_(10'h3FA, 32'h0);
        dump("R9 ro write ignored");

        // R10 identification window
        for (int k = 0; k < 8; k++) rd(10'h3F8 + 10'(k), "R10 id");

        // R11 palette forwarding
        rd(10'h080, "R11 pal read lo");
        rd(10'h0FF, "R11 pal read hi");
        wr_(10'h0A5, 32'hDEAD_BEEF);

        // R12 unmapped edges
        rd(10'd13, "R12 unmapped read");
        rd(10'h07F, "R12 unmapped read");
        rd(10'h100, "R12 unmapped read");
        rd(10'h3F7, "R12 unmapped read");
        wr_(10'd13, 32'hFFFF_FFFF);
        wr_(10'h200, 32'hFFFF_FFFF);
        idle('0);
        rd(10'd12, "R12 mapped no err");
        idle('0);
        dump("R12 write ignored");
        idle('0); idle('0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule